// File: doc/BRIEF.md
# Low-Power Mode Entry and Wakeup Controller

This block decides when the processor core stops its clock and when it resumes. Two sleep depths are supported. In light sleep only the CPU clock is gated. In deep sleep the whole core clock domain stops, both oscillators are switched off and the voltage regulator may drop into a low-power mode. The wakeup sources that may end a sleep depend on the instruction that started it, either wait-for-interrupt or wait-for-event, and on the sleep depth.

On leaving deep sleep the controller does three things in order. If the regulator was in low-power mode, it waits a programmable number of cycles for the regulator to settle. It then enables the internal RC oscillator and waits for that oscillator's ready input. Finally it forces the system clock select to the RC source, reopens the clocks and sends a one-cycle wake pulse to the CPU.

The controller also supports sleep-on-exit. When the lowest-priority handler returns, an ISR-exit strobe can put the core back into light sleep without a new instruction. Analog behaviour of the oscillators and the regulator is represented only by the ready input and the settle count.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the outputs are: `cpu_clk_en`=1, `dom_clk_en`=1, `hick_en`=1, `hext_en`=`hext_on`, `reg_lowpwr`=0, `sysclk_sel`=0 (0 means RC oscillator) and `wake_pulse`=0.
- R2: A `wfi_req` or `wfe_req` pulse while `deep_en`=0 gives `cpu_clk_en`=0 in the next cycle. In light sleep `dom_clk_en`=1, `hick_en`=1, `hext_en`=`hext_on` and `reg_lowpwr`=0. When both requests are present in the same cycle, `wfi_req` wins.
- R3: An `isr_exit` pulse enters light sleep with wait-for-interrupt wake rules, but only when `exit_sleep_en`=1 and `deep_en`=0. Otherwise it is ignored and `cpu_clk_en` stays 1.
- R4: Light sleep entered by `wfi_req` ends in the next cycle on any bit of `periph_irq`, or on any `ext_line` bit whose `ext_evt_mode` bit is 0 (interrupt mode). `periph_pend` is ignored.
- R5: Light sleep entered by `wfe_req` ends on any `periph_pend` bit while `sev_on_pend`=1, or on any `ext_line` bit whose `ext_evt_mode` bit is 1 (event mode). `periph_irq` is ignored, and `periph_pend` is ignored while `sev_on_pend`=0.
- R6: A request with `deep_en`=1 and `lp_sel`=0 enters deep sleep in the next cycle. In deep sleep `cpu_clk_en`, `dom_clk_en`, `hick_en` and `hext_en` are all 0, and `reg_lowpwr` equals `reg_lp_sel` as sampled with the request.
- R7: A request with `deep_en`=1 and `lp_sel`=1 is ignored, and the block stays running.
- R8: Deep sleep entered by `wfi_req` wakes only on an interrupt-mode `ext_line` bit. Deep sleep entered by `wfe_req` wakes only on an event-mode `ext_line` bit. Peripheral lines are ignored.
- R9: If the regulator was in low-power mode and `settle_cfg`=N>0, `hick_en` stays 0 for exactly N cycles after the wake cycle. Otherwise `hick_en` is 1 in the cycle after the wake.
- R10: After `hick_en` rises, the core stays stopped until `hick_ready` is sampled at 1. In the following cycle `cpu_clk_en`=1, `dom_clk_en`=1 and `sysclk_sel`=0.
- R11: `wake_pulse` is high for exactly one cycle, and that cycle is the first cycle with `cpu_clk_en`=1 after any wakeup.
- R12: While running, a change of `sysclk_req` is copied to `sysclk_sel` in the next cycle. A level that is unchanged does not undo the RC selection forced by a deep-sleep exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt sleep request pulse |
| wfe_req | input | 1 | Wait-for-event sleep request pulse |
| deep_en | input | 1 | Selects deep sleep on request |
| exit_sleep_en | input | 1 | Enables sleep-on-exit |
| lp_sel | input | 1 | Selects the lowest mode (not handled; blocks deep entry) |
| reg_lp_sel | input | 1 | Regulator low-power mode during deep sleep |
| isr_exit | input | 1 | Lowest-priority handler return strobe |
| sev_on_pend | input | 1 | Pending peripheral lines count as events |
| periph_irq | input | N_IRQ | Enabled peripheral interrupts |
| periph_pend | input | N_IRQ | Pending peripheral lines not enabled as interrupts |
| ext_line | input | N_EXT | External wake lines |
| ext_evt_mode | input | N_EXT | Per line: 1 event mode, 0 interrupt mode |
| hick_ready | input | 1 | RC oscillator stable |
| hext_on | input | 1 | External oscillator enable requested by software |
| sysclk_req | input | 1 | Software clock choice (0 RC, 1 other) |
| settle_cfg | input | CNT_W | Regulator settle cycles (0 skips the wait) |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| dom_clk_en | output | 1 | Core domain clock gate enable |
| hick_en | output | 1 | RC oscillator enable |
| hext_en | output | 1 | External oscillator enable |
| reg_lowpwr | output | 1 | Regulator in low-power mode |
| sysclk_sel | output | 1 | System clock select (0 RC) |
| wake_pulse | output | 1 | One-cycle wake indication to the CPU |

## Verification
A new sleep request can arrive in the same cycle as the wake pulse, when the CPU has just resumed. The bench asserts `wfi_req` in that cycle and expects the CPU clock to be gated again in the next cycle. This checks that the return to run and the next entry do not mask each other.

The bench also raises `wfi_req`, `wfe_req` and `isr_exit` together. It then judges the chosen wake rule by which source ends the sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_DEEP    = 3'd2,
    ST_REGWAIT = 3'd3,
    ST_OSCWAIT = 3'd4
  } lpm_state_e;
endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel #(
  parameter int N_IRQ = 4,
  parameter int N_EXT = 4
) (
  input  logic             wfe_mode,
  input  logic             deep_mode,
  input  logic [N_IRQ-1:0] periph_irq,
  input  logic [N_IRQ-1:0] periph_pend,
  input  logic             sev_on_pend,
  input  logic [N_EXT-1:0] ext_line,
  input  logic [N_EXT-1:0] ext_evt_mode,
  output logic             wake
);
  logic [N_EXT-1:0] ext_int_hit;
  logic [N_EXT-1:0] ext_evt_hit;

  // split each external line by its configured mode
  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    assign ext_int_hit[g] = ext_line[g] & ~ext_evt_mode[g];
    assign ext_evt_hit[g] = ext_line[g] &  ext_evt_mode[g];
  end

  logic int_src;
  logic evt_src;

  always_comb begin
    evt_src = (|ext_evt_hit) | (sev_on_pend & (|periph_pend));
    if (deep_mode) begin
      int_src = |ext_int_hit;
      evt_src = |ext_evt_hit;
    end else begin
      int_src = (|periph_irq) | (|ext_int_hit);
    end
    wake = wfe_mode ? evt_src : int_src;
  end
endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (run & ~last);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  // R9: the settle window shrinks by one each waiting cycle
  assert_settle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !last && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
  import lpm_pkg::*;
(
  input  lpm_state_e state,
  input  logic       hext_on,
  input  logic       reg_lp,
  output logic       cpu_clk_en,
  output logic       dom_clk_en,
  output logic       hick_en,
  output logic       hext_en,
  output logic       reg_lowpwr
);
  always_comb begin
    cpu_clk_en = 1'b0;
    dom_clk_en = 1'b0;
    hick_en    = 1'b0;
    hext_en    = 1'b0;
    reg_lowpwr = 1'b0;
    case (state)
      ST_RUN: begin
        cpu_clk_en = 1'b1;
        dom_clk_en = 1'b1;
        hick_en    = 1'b1;
        hext_en    = hext_on;
      end
      ST_SLEEP: begin
        dom_clk_en = 1'b1;
        hick_en    = 1'b1;
        hext_en    = hext_on;
      end
      ST_DEEP:    reg_lowpwr = reg_lp;
      ST_REGWAIT: ;
      ST_OSCWAIT: hick_en = 1'b1;
      default: begin
        cpu_clk_en = 1'b1;
        dom_clk_en = 1'b1;
        hick_en    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 4,
  parameter int N_EXT = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_req,
  input  logic             wfe_req,
  input  logic             deep_en,
  input  logic             exit_sleep_en,
  input  logic             lp_sel,
  input  logic             reg_lp_sel,
  input  logic             isr_exit,
  input  logic             sev_on_pend,
  input  logic [N_IRQ-1:0] periph_irq,
  input  logic [N_IRQ-1:0] periph_pend,
  input  logic [N_EXT-1:0] ext_line,
  input  logic [N_EXT-1:0] ext_evt_mode,
  input  logic             hick_ready,
  input  logic             hext_on,
  input  logic             sysclk_req,
  input  logic [CNT_W-1:0] settle_cfg,
  output logic             cpu_clk_en,
  output logic             dom_clk_en,
  output logic             hick_en,
  output logic             hext_en,
  output logic             reg_lowpwr,
  output logic             sysclk_sel,
  output logic             wake_pulse
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  lpm_state_e state_q, state_d;
  logic mode_wfe_q, mode_wfe_d;
  logic reg_lp_q, reg_lp_d;
  logic wake_q, wake_d;
  logic sel_q, sel_d, sel_en;
  logic req_q;
  logic entry_en;
  logic wake;
  logic settle_load;
  logic settle_last;
  logic go_wfi, go_wfe, go_isr;

  lpm_wake_sel #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) i_wake_sel (
    .wfe_mode    (mode_wfe_q),
    .deep_mode   (state_q == ST_DEEP),
    .periph_irq  (periph_irq),
    .periph_pend (periph_pend),
    .sev_on_pend (sev_on_pend),
    .ext_line    (ext_line),
    .ext_evt_mode(ext_evt_mode),
    .wake        (wake)
  );

  lpm_settle_cnt #(.CNT_W(CNT_W)) i_settle (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (settle_load),
    .load_val(settle_cfg),
    .run     (state_q == ST_REGWAIT),
    .last    (settle_last)
  );

  lpm_out_dec i_out_dec (
    .state     (state_q),
    .hext_on   (hext_on),
    .reg_lp    (reg_lp_q),
    .cpu_clk_en(cpu_clk_en),
    .dom_clk_en(dom_clk_en),
    .hick_en   (hick_en),
    .hext_en   (hext_en),
    .reg_lowpwr(reg_lowpwr)
  );

  // request priority: wait-for-interrupt, wait-for-event, then handler exit
  assign go_wfi = wfi_req;
  assign go_wfe = wfe_req & ~wfi_req;
  assign go_isr = isr_exit & exit_sleep_en & ~deep_en & ~wfi_req & ~wfe_req;

  always_comb begin
    state_d     = state_q;
    mode_wfe_d  = mode_wfe_q;
    reg_lp_d    = reg_lp_q;
    settle_load = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (go_wfi || go_wfe) begin
          if (!deep_en) begin
            state_d    = ST_SLEEP;
            mode_wfe_d = go_wfe;
          end else if (!lp_sel) begin
            state_d    = ST_DEEP;
            mode_wfe_d = go_wfe;
            reg_lp_d   = reg_lp_sel;
          end
        end else if (go_isr) begin
          state_d    = ST_SLEEP;
          mode_wfe_d = 1'b0;
        end
      end
      ST_SLEEP: if (wake) state_d = ST_RUN;
      ST_DEEP: begin
        if (wake) begin
          if (reg_lp_q && settle_cfg != '0) begin
            state_d     = ST_REGWAIT;
            settle_load = 1'b1;
          end else begin
            state_d = ST_OSCWAIT;
          end
        end
      end
      ST_REGWAIT: if (settle_last) state_d = ST_OSCWAIT;
      ST_OSCWAIT: if (hick_ready) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  assign entry_en = (state_q == ST_RUN) && (state_d != ST_RUN);
  assign wake_d   = (state_d == ST_RUN) && (state_q != ST_RUN);

  always_comb begin
    sel_en = 1'b0;
    sel_d  = sel_q;
    if (state_q == ST_OSCWAIT && hick_ready) begin
      sel_en = 1'b1;
      sel_d  = 1'b0;
    end else if (state_q == ST_RUN && sysclk_req != req_q) begin
      sel_en = 1'b1;
      sel_d  = sysclk_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_RUN;
      mode_wfe_q <= 1'b0;
      reg_lp_q   <= 1'b0;
      wake_q     <= 1'b0;
      sel_q      <= 1'b0;
      req_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
      req_q   <= sysclk_req;
      if (entry_en) begin
        mode_wfe_q <= mode_wfe_d;
        reg_lp_q   <= reg_lp_d;
      end
      if (sel_en) sel_q <= sel_d;
    end
  end

  assign sysclk_sel = sel_q;
  assign wake_pulse = wake_q;

  // R11: the wake pulse marks a running CPU clock and lasts one cycle
  assert_pulse_running_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    wake_pulse |-> cpu_clk_en);
  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    wake_pulse |=> !wake_pulse);
  // R10: no exit from the oscillator wait without a ready oscillator
  assert_osc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_OSCWAIT && !hick_ready) |=> (state_q == ST_OSCWAIT && !cpu_clk_en));
  assert_rc_forced_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_OSCWAIT && hick_ready) |=> (!sysclk_sel && cpu_clk_en));
  // R8: deep sleep is left only through the wake selector
  assert_deep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_DEEP && !wake) |=> (state_q == ST_DEEP));
  // R9: the regulator leaves low power while the core is still stopped
  assert_reg_before_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(reg_lowpwr) |-> !cpu_clk_en);
endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic wfi_req, wfe_req, deep_en, exit_sleep_en, lp_sel, reg_lp_sel;
  logic isr_exit, sev_on_pend, hick_ready, hext_on, sysclk_req;
  logic [3:0] periph_irq, periph_pend, ext_line, ext_evt_mode;
  logic [7:0] settle_cfg;
  logic cpu_clk_en, dom_clk_en, hick_en, hext_en, reg_lowpwr, sysclk_sel, wake_pulse;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  lpm_ctrl i_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .deep_en(deep_en), .exit_sleep_en(exit_sleep_en), .lp_sel(lp_sel),
    .reg_lp_sel(reg_lp_sel), .isr_exit(isr_exit), .sev_on_pend(sev_on_pend),
    .periph_irq(periph_irq), .periph_pend(periph_pend), .ext_line(ext_line),
    .ext_evt_mode(ext_evt_mode), .hick_ready(hick_ready), .hext_on(hext_on),
    .sysclk_req(sysclk_req), .settle_cfg(settle_cfg),
    .cpu_clk_en(cpu_clk_en), .dom_clk_en(dom_clk_en), .hick_en(hick_en),
    .hext_en(hext_en), .reg_lowpwr(reg_lowpwr), .sysclk_sel(sysclk_sel),
    .wake_pulse(wake_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic req(input int wfe);
    if (wfe != 0) wfe_req = 1'b1; else wfi_req = 1'b1;
    tick();
    wfi_req = 1'b0;
    wfe_req = 1'b0;
  endtask

  task automatic clear_src();
    periph_irq = '0; periph_pend = '0; ext_line = '0; sev_on_pend = 1'b0;
  endtask

  // 0 irq, 1 pend+sev, 2 pend no sev, 3 ext interrupt mode, 4 ext event mode
  task automatic apply_src(input int s, input int b);
    case (s)
      0: periph_irq = 4'(1 << b);
      1: begin sev_on_pend = 1'b1; periph_pend = 4'(1 << b); end
      2: begin sev_on_pend = 1'b0; periph_pend = 4'(1 << b); end
      3: begin ext_evt_mode = 4'h0; ext_line = 4'(1 << b); end
      default: begin ext_evt_mode = 4'hF; ext_line = 4'(1 << b); end
    endcase
  endtask

  task automatic rescue(input int wfe, input int deep);
    if (wfe != 0) begin ext_evt_mode = 4'hF; ext_line = 4'h1; end
    else if (deep != 0) begin ext_evt_mode = 4'h0; ext_line = 4'h1; end
    else periph_irq = 4'h1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    wfi_req = 0; wfe_req = 0; deep_en = 0; exit_sleep_en = 0; lp_sel = 0;
    reg_lp_sel = 0; isr_exit = 0; hick_ready = 0; hext_on = 1; sysclk_req = 0;
    ext_evt_mode = '0; settle_cfg = '0;
    clear_src();
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 dom_clk_en", dom_clk_en, 1);
    chk("R1 hick_en", hick_en, 1);
    chk("R1 hext_en", hext_en, 1);
    chk("R1 reg_lowpwr", reg_lowpwr, 0);
    chk("R1 sysclk_sel", sysclk_sel, 0);
    chk("R1 wake_pulse", wake_pulse, 0);

    // light sleep: every source type on every bit, both instructions
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 5; s++) begin
        for (int b = 0; b < 4; b++) begin
          bit exp_w;
          req(m);
          chk("R2 cpu gated", cpu_clk_en, 0);
          chk("R2 dom running", dom_clk_en, 1);
          chk("R2 rc running", hick_en, 1);
          chk("R2 hext kept", hext_en, 1);
          chk("R2 regulator normal", reg_lowpwr, 0);
          apply_src(s, b);
          exp_w = (m == 0) ? (s == 0 || s == 3) : (s == 1 || s == 4);
          tick();
          if (m == 0) chk("R4 wfi sleep wake", cpu_clk_en, int'(exp_w));
          else        chk("R5 wfe sleep wake", cpu_clk_en, int'(exp_w));
          chk("R11 pulse on wake", wake_pulse, int'(exp_w));
          clear_src();
          if (!exp_w) begin
            rescue(m, 0);
            tick();
            chk("R11 pulse after rescue", wake_pulse, 1);
            clear_src();
          end
          tick();
          chk("R11 pulse single", wake_pulse, 0);
        end
      end
    end

    // deep sleep: source sweep, regulator normal, no settle wait
    deep_en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 5; s++) begin
        for (int b = 0; b < 4; b++) begin
          bit exp_w;
          req(m);
          chk("R6 cpu off", cpu_clk_en, 0);
          chk("R6 dom off", dom_clk_en, 0);
          chk("R6 rc off", hick_en, 0);
          chk("R6 hext off", hext_en, 0);
          chk("R6 regulator normal", reg_lowpwr, 0);
          apply_src(s, b);
          exp_w = (m == 0) ? (s == 3) : (s == 4);
          tick();
          chk("R8 deep wake source", hick_en, int'(exp_w));
          clear_src();
          if (!exp_w) begin
            rescue(m, 1);
            tick();
            chk("R8 deep rescue", hick_en, 1);
            clear_src();
          end
          tick();
          chk("R10 waits for rc", cpu_clk_en, 0);
          hick_ready = 1'b1;
          tick();
          chk("R10 cpu resumes", cpu_clk_en, 1);
          chk("R10 dom resumes", dom_clk_en, 1);
          chk("R10 rc selected", sysclk_sel, 0);
          chk("R11 deep wake pulse", wake_pulse, 1);
          hick_ready = 1'b0;
          tick();
        end
      end
    end

    // regulator settle window and clock select
    for (int rl = 0; rl < 2; rl++) begin
      for (int n = 0; n < 6; n++) begin
        int cnt;
        sysclk_req = 1'b1;
        tick();
        chk("R12 follows request", sysclk_sel, 1);
        reg_lp_sel = rl[0];
        settle_cfg = 8'(n);
        req(0);
        chk("R6 regulator mode", reg_lowpwr, rl);
        ext_evt_mode = 4'h0; ext_line = 4'h1;
        tick();
        clear_src();
        cnt = 0;
        while (!hick_en && cnt < 20) begin
          cnt++;
          tick();
        end
        chk("R9 settle cycles", cnt, (rl == 1) ? n : 0);
        tick();
        tick();
        chk("R10 held without ready", cpu_clk_en, 0);
        hick_ready = 1'b1;
        tick();
        hick_ready = 1'b0;
        chk("R10 resumed", cpu_clk_en, 1);
        chk("R10 forced rc", sysclk_sel, 0);
        tick();
        chk("R12 level not reapplied", sysclk_sel, 0);
        sysclk_req = 1'b0;
        tick();
      end
    end
    reg_lp_sel = 1'b0;
    settle_cfg = '0;

    // R7 lowest-mode select blocks entry
    lp_sel = 1'b1;
    req(0);
    chk("R7 stays running", cpu_clk_en, 1);
    chk("R7 domain running", dom_clk_en, 1);
    lp_sel = 1'b0;
    deep_en = 1'b0;

    // R3 sleep-on-exit gating
    isr_exit = 1'b1; tick(); isr_exit = 1'b0;
    chk("R3 ignored without enable", cpu_clk_en, 1);
    exit_sleep_en = 1'b1; deep_en = 1'b1;
    isr_exit = 1'b1; tick(); isr_exit = 1'b0;
    chk("R3 ignored with deep bit", cpu_clk_en, 1);
    chk("R3 domain untouched", dom_clk_en, 1);
    deep_en = 1'b0;
    isr_exit = 1'b1; tick(); isr_exit = 1'b0;
    chk("R3 enters sleep", cpu_clk_en, 0);
    ext_evt_mode = 4'hF; ext_line = 4'h2;
    tick();
    chk("R3 event does not wake", cpu_clk_en, 0);
    clear_src();
    periph_irq = 4'h8;
    tick();
    chk("R3 interrupt wakes", cpu_clk_en, 1);
    clear_src();
    exit_sleep_en = 1'b0;

    // coincidence: request in the wake cycle
    wfi_req = 1'b1;
    chk("R11 pulse in wake cycle", wake_pulse, 1);
    tick();
    wfi_req = 1'b0;
    chk("R2 re-entry in wake cycle", cpu_clk_en, 0);
    periph_irq = 4'h1; tick(); clear_src(); tick();

    // R2 priority: all three requests at once, wfi rules apply
    wfi_req = 1'b1; wfe_req = 1'b1; isr_exit = 1'b1; exit_sleep_en = 1'b1;
    tick();
    wfi_req = 1'b0; wfe_req = 1'b0; isr_exit = 1'b0; exit_sleep_en = 1'b0;
    chk("R2 combined entry", cpu_clk_en, 0);
    sev_on_pend = 1'b1; periph_pend = 4'h4;
    tick();
    chk("R2 wfi wins over wfe", cpu_clk_en, 0);
    clear_src();
    periph_irq = 4'h2;
    tick();
    chk("R2 wfi rule wakes", cpu_clk_en, 1);
    clear_src();
    tick();

    finish_run();
  end
endmodule